// File: doc/BRIEF.md
# Event-Capture Status Register Bank

This block holds a row of sticky status bits. Each bit watches one synchronous hardware event line and records it according to a capture mode fixed at build time. A bit either tracks a level (it is set while its line sits high, or while it sits low) or a transition (it is set on a rising change, or on a falling change). Once set, a bit stays set until it is cleared. Each bit is cleared in one of two ways, also fixed at build time. Clear-on-read bits empty themselves when the status word is read. Write-one-to-clear bits are cleared only by a status write that carries a 1 in their position.

Software reaches the bank over a small register bus: an address, a read strobe, a write strobe, write data, and read data registered one cycle after the read strobe. A second register holds a per-bit interrupt enable vector. A single interrupt line is raised whenever any captured bit is also enabled.

If a capture and a clear land on the same bit in the same cycle, the capture wins, so no event is lost. Edge-mode bits compare their line with its value one cycle earlier. In the first cycle after reset they cannot fire, because no earlier value exists yet.

Top module: `evcap_bank`

## Requirements
- R1: After reset, every status bit and every enable bit is 0, `irq` is 0 and `rd_data` is 0.
- R2: Each bit's 3-bit mode code is `MODES[3*i+2:3*i]`. Bits [1:0] choose the capture: 0 level-high, 1 level-low, 2 rising edge, 3 falling edge. Bit 2 chooses the clear: 0 clear-on-read, 1 write-one-to-clear. A level-high bit is set at the clock edge where its input is 1, and then holds.
- R3: A level-low bit is set at the clock edge where its input is 0, and then holds.
- R4: A rising-edge bit is set at the clock edge where its input is 1 and was 0 at the previous edge. A constant input or a falling change never sets it.
- R5: A falling-edge bit is set at the clock edge where its input is 0 and was 1 at the previous edge. A constant input or a rising change never sets it.
- R6: An edge-mode bit is never set at the first clock edge after reset ends, whatever its input is.
- R7: A read at address 0 returns the status word on `rd_data` one cycle later and clears the clear-on-read bits. Write-one-to-clear bits are unaffected by reads, and clear-on-read bits are unaffected by any write.
- R8: A write at address 0 clears each write-one-to-clear bit whose `wr_data` bit is 1. Bits written with 0 are left unchanged.
- R9: When a bit's set condition and its clear occur in the same cycle, the bit is 1 afterwards.
- R10: Address 1 holds the enable vector. A write there loads `wr_data`, and a read returns the stored vector one cycle later. `irq` is 1 exactly when some status bit and its enable bit are both 1, and it follows the stored state with no extra delay.
- R11: A read at address 2 or 3 returns 0. In cycles without a read, `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_in | input | WIDTH | Synchronous event lines, one per status bit |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address (0 status, 1 enable) |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Registered read data |
| irq | output | 1 | Interrupt, OR of enabled captured bits |

## Verification
The assertions assume that `ev_in` and the bus inputs are synchronous to `clk` and stable around its rising edge. They also assume that reset is released only through the internal synchroniser, so that the first active cycle is the one without an edge history. The bench drives every input just after a rising edge and samples on the falling edge. It holds the event lines constant across reset release while edge bits sit at their post-transition levels, which tests the first-cycle rule. A random phase then mixes reads and writes freely with changing event lines, so set-and-clear collisions occur in every mode.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int MODE_W = 3;

  // capture kinds, mode code bits [1:0]
  localparam logic [1:0] CAP_LVL_HI = 2'd0;
  localparam logic [1:0] CAP_LVL_LO = 2'd1;
  localparam logic [1:0] CAP_RISE   = 2'd2;
  localparam logic [1:0] CAP_FALL   = 2'd3;

  // register addresses
  localparam int REG_STATUS = 0;
  localparam int REG_ENABLE = 1;
endpackage

// File: rtl/evcap_rstsync.sv
module evcap_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/evcap_cell.sv
module evcap_cell
  import evcap_pkg::*;
#(
  parameter logic [MODE_W-1:0] MODE = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic ev_in,
  input  logic rd_clr,
  input  logic wr_clr,
  output logic stat
);
  localparam logic [1:0] KIND = MODE[1:0];
  localparam logic       W1C  = MODE[2];

  logic prev_q;
  logic stat_q;
  logic hit;
  logic clr;
  logic stat_d;
  logic stat_en;

  always_comb begin
    case (KIND)
      CAP_LVL_HI: hit = ev_in;
      CAP_LVL_LO: hit = ~ev_in;
      CAP_RISE:   hit = armed & ~prev_q & ev_in;
      default:    hit = armed & prev_q & ~ev_in;
    endcase
    clr     = W1C ? wr_clr : rd_clr;
    stat_en = hit | clr;
    stat_d  = hit | (stat_q & ~clr);   // capture wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= ev_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat = stat_q;

  generate
    if (KIND == CAP_LVL_HI) begin : g_a_hi
      assert_lvl_hi_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in |=> stat_q);
    end else if (KIND == CAP_LVL_LO) begin : g_a_lo
      assert_lvl_lo_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_in |=> stat_q);
    end else if (KIND == CAP_RISE) begin : g_a_rise
      assert_rise_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(ev_in) && ev_in) |=> stat_q);
      assert_no_first_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !stat_q);
    end else begin : g_a_fall
      assert_fall_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ev_in) && !ev_in) |=> stat_q);
      assert_no_first_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !stat_q);
    end

    if (W1C) begin : g_a_w1c
      assert_w1c_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !wr_clr) |=> stat_q);
    end else begin : g_a_rc
      assert_rc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !rd_clr) |=> stat_q);
    end
  endgenerate
endmodule

// File: rtl/evcap_regif.sv
module evcap_regif
  import evcap_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  stat,
  output logic [WIDTH-1:0]  rd_data,
  output logic [WIDTH-1:0]  en,
  output logic              st_rd,
  output logic              st_wr
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(REG_ENABLE);

  logic [WIDTH-1:0] en_q;
  logic [WIDTH-1:0] rd_q;
  logic [WIDTH-1:0] rd_d;
  logic             en_we;

  always_comb begin
    st_rd = rd_en & (addr == A_STAT);
    st_wr = wr_en & (addr == A_STAT);
    en_we = wr_en & (addr == A_EN);
    case (addr)
      A_STAT:  rd_d = stat;
      A_EN:    rd_d = en_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
  assign en      = en_q;

  assert_en_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EN) |=> en_q == $past(wr_data));
  assert_en_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_EN) |=> rd_q == $past(en_q));
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != A_STAT && addr != A_EN) |=> rd_q == '0);
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/evcap_bank.sv
module evcap_bank
  import evcap_pkg::*;
#(
  parameter int                    WIDTH  = 8,
  parameter int                    ADDR_W = 2,
  parameter logic [MODE_W*WIDTH-1:0] MODES = 24'hFAC688
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  ev_in,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  output logic              irq
);
  logic             rst_i_n;
  logic             armed_q;
  logic [WIDTH-1:0] stat;
  logic [WIDTH-1:0] en;
  logic             st_rd;
  logic             st_wr;

  evcap_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // edge history becomes valid one cycle after reset ends
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) armed_q <= 1'b0;
    else          armed_q <= 1'b1;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      evcap_cell #(.MODE(MODES[MODE_W*i +: MODE_W])) u_cell (
        .clk    (clk),
        .rst_n  (rst_i_n),
        .armed  (armed_q),
        .ev_in  (ev_in[i]),
        .rd_clr (st_rd),
        .wr_clr (st_wr & wr_data[i]),
        .stat   (stat[i])
      );
    end
  endgenerate

  evcap_regif #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regif (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .stat    (stat),
    .rd_data (rd_data),
    .en      (en),
    .st_rd   (st_rd),
    .st_wr   (st_wr)
  );

  assign irq = |(stat & en);

  assert_irq_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (en == '0) |-> !irq);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !armed_q |-> (rd_data == '0 && !irq));
endmodule

// File: tb/sim_evcap_bank.sv
`timescale 1ns/1ps
module sim_evcap_bank;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] ev_in;
  logic         rd_en, wr_en;
  logic [1:0]   addr;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic         irq;

  int    vectors = 0;
  int    fails   = 0;
  bit    model_on = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  // model state: bit i has mode code i (kinds 0..3, w1c for i>=4)
  logic [W-1:0] m_stat, m_en, m_prev, m_rd;

  always #4 clk = ~clk;   // 125 MHz

  evcap_bank #(.WIDTH(W), .ADDR_W(2), .MODES(24'hFAC688)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (model_on) begin
      logic [W-1:0] nxt;
      for (int i = 0; i < W; i++) begin
        bit set, clr;
        case (i % 4)
          0: set = ev_in[i];
          1: set = !ev_in[i];
          2: set = !m_prev[i] && ev_in[i];
          default: set = m_prev[i] && !ev_in[i];
        endcase
        if (i < 4) clr = rd_en && addr == 2'd0;
        else       clr = wr_en && addr == 2'd0 && wr_data[i];
        nxt[i] = set || (m_stat[i] && !clr);
      end
      if (rd_en) m_rd = (addr == 2'd0) ? m_stat : (addr == 2'd1) ? m_en : '0;
      if (wr_en && addr == 2'd1) m_en = wr_data;
      m_stat = nxt;
      m_prev = ev_in;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      chk({phase, " rd_data"}, rd_data, m_rd);
      chk({phase, " irq"}, {7'd0, irq}, {7'd0, |(m_stat & m_en)});
    end
  end

  task automatic op(input bit r, input bit w, input logic [1:0] a,
                    input logic [W-1:0] d, input logic [W-1:0] ev);
    @(posedge clk); #1;
    rd_en = r; wr_en = w; addr = a; wr_data = d; ev_in = ev;
  endtask

  logic [W-1:0] idle_ev = 8'h66;   // no level capture, edge bits at rest

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 0; wr_en = 0; addr = 0; wr_data = 0;
    ev_in = idle_ev;   // rising bits high, falling bits low: R6 setup
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    m_stat = '0; m_en = '0; m_rd = '0; m_prev = ev_in;
    model_on = 1'b1;

    phase = "R6";
    op(1, 0, 2'd0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R6 no edge after reset", rd_data, 8'h00);
    phase = "R1";
    op(1, 0, 2'd1, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R1 enable reset", rd_data, 8'h00);

    phase = "R2";
    op(0, 0, 0, 0, idle_ev | 8'h11); op(0, 0, 0, 0, idle_ev);
    op(1, 0, 2'd0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R2 level-high captured", rd_data, 8'h11);
    op(1, 0, 2'd0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R7 rc cleared, w1c kept", rd_data, 8'h10);

    phase = "R3";
    op(0, 0, 0, 0, idle_ev & ~8'h22); op(0, 0, 0, 0, idle_ev);
    op(1, 0, 2'd0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R3 level-low captured", rd_data, 8'h32);

    phase = "R4";
    op(0, 0, 0, 0, idle_ev & ~8'h44); op(0, 0, 0, 0, idle_ev & ~8'h44);
    op(1, 0, 2'd0, 0, idle_ev & ~8'h44); op(0, 0, 0, 0, idle_ev & ~8'h44);
    @(negedge clk); chk("R4 falling ignored", rd_data & 8'h44, 8'h00);
    op(0, 0, 0, 0, idle_ev); op(1, 0, 2'd0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R4 rising captured", rd_data & 8'h44, 8'h44);

    phase = "R5";
    op(0, 0, 0, 0, idle_ev | 8'h88); op(0, 0, 0, 0, idle_ev | 8'h88);
    op(1, 0, 2'd0, 0, idle_ev | 8'h88); op(0, 0, 0, 0, idle_ev | 8'h88);
    @(negedge clk); chk("R5 rising ignored", rd_data & 8'h88, 8'h00);
    op(0, 0, 0, 0, idle_ev); op(1, 0, 2'd0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R5 falling captured", rd_data & 8'h88, 8'h88);

    phase = "R8";
    op(0, 0, 0, 0, idle_ev | 8'h01);             // set rc bit 0
    op(0, 1, 2'd0, 8'hAF, idle_ev);              // clear w1c 5,7; rc bits untouched
    op(1, 0, 2'd0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R8 w1c partial clear", rd_data & 8'hF1, 8'h51);
    phase = "R7";
    op(0, 1, 2'd0, 8'h0F, idle_ev); op(1, 0, 2'd0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R7 rc bits ignore writes", rd_data & 8'h0F, 8'h00);

    phase = "R9";
    op(1, 1, 2'd0, 8'hFF, idle_ev | 8'h11);      // set and clear collide
    op(0, 0, 0, 0, idle_ev);
    op(1, 0, 2'd0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R9 set wins", rd_data & 8'h11, 8'h11);

    phase = "R10";
    op(0, 1, 2'd1, 8'hA5, idle_ev); op(1, 0, 2'd1, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R10 enable readback", rd_data, 8'hA5);
    op(0, 0, 0, 0, idle_ev | 8'h01); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R10 irq raised", {7'd0, irq}, 8'h01);

    phase = "R11";
    op(1, 0, 2'd2, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R11 unmapped zero", rd_data, 8'h00);
    op(1, 0, 2'd1, 0, idle_ev); op(0, 0, 0, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R11 hold without read", rd_data, 8'hA5);
    op(1, 0, 2'd3, 0, idle_ev); op(0, 0, 0, 0, idle_ev);
    @(negedge clk); chk("R11 unmapped zero", rd_data, 8'h00);

    phase = "R9 random";
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] r = $urandom;
      op(r[0], r[1], r[3:2], r[11:4], r[19:12]);
    end
    op(0, 0, 0, 0, idle_ev);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule